// File: doc/BRIEF.md
# Bitstream Return-to-Zero Pulse Reformatter

This block turns a one-bit sigma-delta stream into return-to-zero pulses for a discrete switching DAC. The stream advances once every two master-clock periods (nominally 16.9344 MHz, 44.1 kHz family only). Each captured bit is steered onto one of two phase lines. A 1 goes to the positive phase and a 0 goes to the negative phase. A pulse is emitted only during the high half of each master cycle, so every pulse carries the same half-cycle of energy whatever the neighbouring bits are.

The logic runs on one fast clock at twice the master rate. An internal toggle marks the high and low halves of each master cycle, and a counter marks where each bit slot begins. The encoded phases pass through a pre-latch stage and then a final latch stage. The final stage drives a true and a complemented output for each phase, which gives four element outputs for a later analog summing network. Because every output is a flop that is loaded once per half cycle, a pulse is always a whole fast-clock cycle long or absent. Late gating cannot clip a pulse into a runt.

Top module: `bitstream_rtz_reformatter`

## Requirements
- R1: While `rst` is high, and on every cycle after it until the first pulse, `elem_pos` and `elem_neg` are 0 and `elem_pos_n` and `elem_neg_n` are 1. A reset mid-stream returns the outputs to this idle state at the first reset edge.
- R2: A positive pulse (`elem_pos` = 1) appears only for a held bit of value 1, and only in a cycle that stands for the high half of a master cycle.
- R3: A negative pulse (`elem_neg` = 1) appears only for a held bit of value 0, and only in a high-half cycle.
- R4: `elem_pos` and `elem_neg` are never 1 in the same cycle.
- R5: Every pulse lasts exactly one fast-clock cycle (half a master cycle), and the following cycle has no pulse on either phase, so there are no runt or merged pulses.
- R6: Each bit slot produces exactly MCLK_PER_BIT pulses of the held bit's polarity. Over a stream, the positive count is MCLK_PER_BIT times the number of held 1 slots, and the negative count is MCLK_PER_BIT times the number of held 0 slots.
- R7: `elem_pos_n` is always the inverse of `elem_pos`, and `elem_neg_n` is always the inverse of `elem_neg`. Each of the four outputs comes from its own flop.
- R8: A bit slot lasts 2*MCLK_PER_BIT fast cycles. The first slot starts at the first edge after reset is released. `bit_in` is captured only at a slot's first edge and only if `bit_valid` is high there. At any other edge, `bit_in` is ignored even when `bit_valid` is high. A slot without a valid sample repeats the previous bit. Before any bit has been captured, no pulses are emitted.
- R9: Latency is fixed. With the capture edge counted as edge 0, the pulses of that slot are visible after edges PRE_STAGES+1, PRE_STAGES+3, and so on in steps of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the master clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Bitstream sample |
| bit_valid | input | 1 | Marks that `bit_in` holds a new sample |
| elem_pos | output | 1 | Positive phase, true output |
| elem_pos_n | output | 1 | Positive phase, complemented output |
| elem_neg | output | 1 | Negative phase, true output |
| elem_neg_n | output | 1 | Negative phase, complemented output |

## Verification
The bench builds the block with MCLK_PER_BIT = 2 and PRE_STAGES = 1, so one slot is only four fast cycles. With so short a slot, every output cycle of several hundred slots can be compared one by one against a waveform the bench derives arithmetically from the slot index and the pipeline depth. Slots with `bit_valid` dropped, opposite data driven on non-capture edges, uniform runs of ones and zeros, and mid-stream resets all fit into a few thousand cycles.

// File: rtl/rtz_pkg.sv
package rtz_pkg;

    // One encoded sample of the two return-to-zero phase lines.
    typedef struct packed {
        logic pos;
        logic neg;
    } rtz_phase_t;

    // Which half of the master clock period the current fast cycle stands for.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

    localparam rtz_phase_t RTZ_IDLE = '{pos: 1'b0, neg: 1'b0};

    // A pulse exists only in the high half, and only once a bit has been held.
    function automatic rtz_phase_t rtz_encode(input half_e half, input logic armed, input logic bit_val);
        rtz_phase_t p;
        p.pos = (half == HALF_HIGH) && armed && bit_val;
        p.neg = (half == HALF_HIGH) && armed && !bit_val;
        return p;
    endfunction

endpackage

// File: rtl/rtz_phase_timer.sv
module rtz_phase_timer
    import rtz_pkg::*;
#(
    parameter int MCLK_PER_BIT = 2
) (
    input  logic  clk,
    input  logic  rst,
    output half_e half,
    output logic  slot_start
);
    localparam int CW = (MCLK_PER_BIT > 1) ? $clog2(MCLK_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST_MCYC = CW'(MCLK_PER_BIT - 1);

    half_e          half_q;
    logic [CW-1:0]  mcyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HALF_LOW;
            mcyc_q <= '0;
        end else begin
            half_q <= (half_q == HALF_LOW) ? HALF_HIGH : HALF_LOW;
            if (half_q == HALF_HIGH) begin
                mcyc_q <= (mcyc_q == LAST_MCYC) ? '0 : mcyc_q + 1'b1;
            end
        end
    end

    assign half       = half_q;
    assign slot_start = (half_q == HALF_LOW) && (mcyc_q == '0);

endmodule

// File: rtl/rtz_sample_hold.sv
module rtz_sample_hold (
    input  logic clk,
    input  logic rst,
    input  logic slot_start,
    input  logic bit_in,
    input  logic bit_valid,
    output logic held_bit,
    output logic armed
);
    logic bit_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (slot_start && bit_valid) begin
            bit_q   <= bit_in;
            armed_q <= 1'b1;
        end
    end

    assign held_bit = bit_q;
    assign armed    = armed_q;

endmodule

// File: rtl/rtz_reclock.sv
module rtz_reclock
    import rtz_pkg::*;
#(
    parameter int PRE_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  rtz_phase_t enc,
    output logic       pos,
    output logic       pos_n,
    output logic       neg,
    output logic       neg_n
);
    rtz_phase_t pre_q [PRE_STAGES];
    rtz_phase_t fin_q;
    rtz_phase_t fin_n_q;

    // Pre-latch chain: resynchronises the gated phases before the final latch.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PRE_STAGES; i++) pre_q[i] <= RTZ_IDLE;
        end else begin
            pre_q[0] <= enc;
            for (int i = 1; i < PRE_STAGES; i++) pre_q[i] <= pre_q[i-1];
        end
    end

    // Final latch pair: separate true and complement flops per phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q   <= RTZ_IDLE;
            fin_n_q <= '{pos: 1'b1, neg: 1'b1};
        end else begin
            fin_q       <= pre_q[PRE_STAGES-1];
            fin_n_q.pos <= ~pre_q[PRE_STAGES-1].pos;
            fin_n_q.neg <= ~pre_q[PRE_STAGES-1].neg;
        end
    end

    assign pos   = fin_q.pos;
    assign neg   = fin_q.neg;
    assign pos_n = fin_n_q.pos;
    assign neg_n = fin_n_q.neg;

endmodule

// File: rtl/bitstream_rtz_reformatter.sv
module bitstream_rtz_reformatter
    import rtz_pkg::*;
#(
    parameter int MCLK_PER_BIT = 2,
    parameter int PRE_STAGES   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_valid,
    output logic elem_pos,
    output logic elem_pos_n,
    output logic elem_neg,
    output logic elem_neg_n
);
    half_e      half;
    logic       slot_start;
    logic       held_bit;
    logic       armed;
    rtz_phase_t enc;

    rtz_phase_timer #(.MCLK_PER_BIT(MCLK_PER_BIT)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .half       (half),
        .slot_start (slot_start)
    );

    rtz_sample_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .held_bit   (held_bit),
        .armed      (armed)
    );

    always_comb enc = rtz_encode(half, armed, held_bit);

    rtz_reclock #(.PRE_STAGES(PRE_STAGES)) u_reclock (
        .clk   (clk),
        .rst   (rst),
        .enc   (enc),
        .pos   (elem_pos),
        .pos_n (elem_pos_n),
        .neg   (elem_neg),
        .neg_n (elem_neg_n)
    );

endmodule

// File: rtl/rtz_checker.sv
module rtz_checker (
    input logic clk,
    input logic rst,
    input logic pos,
    input logic pos_n,
    input logic neg,
    input logic neg_n
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) rst_d <= rst;

    // R1: after a reset edge the outputs sit at idle
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            assert_reset_idle_R1: assert (pos == 1'b0 && neg == 1'b0 && pos_n == 1'b1 && neg_n == 1'b1);
        end
    end

    assert_phase_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(pos && neg));

    assert_half_width_R5: assert property (@(posedge clk) disable iff (rst)
        (pos || neg) |=> !(pos || neg));

    assert_pos_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        pos_n == !pos);

    assert_neg_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        neg_n == !neg);

endmodule

bind bitstream_rtz_reformatter rtz_checker u_rtz_checker (
    .clk   (clk),
    .rst   (rst),
    .pos   (elem_pos),
    .pos_n (elem_pos_n),
    .neg   (elem_neg),
    .neg_n (elem_neg_n)
);

// File: tb/test_bitstream_rtz_reformatter.sv
module test_bitstream_rtz_reformatter;
    localparam int M    = 2;
    localparam int P    = 1;
    localparam int SLOT = 2 * M;
    localparam int MAXS = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic elem_pos, elem_pos_n, elem_neg, elem_neg_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic bits [MAXS];
    logic vals [MAXS];
    logic held [MAXS];
    logic arm  [MAXS];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    bitstream_rtz_reformatter #(.MCLK_PER_BIT(M), .PRE_STAGES(P)) i_bitstream_rtz_reformatter (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .elem_pos   (elem_pos),
        .elem_pos_n (elem_pos_n),
        .elem_neg   (elem_neg),
        .elem_neg_n (elem_neg_n)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Outputs must be idle (R1); checked after each reset edge.
    task automatic do_reset(input int cycles);
        rst = 1'b1;
        bit_valid = 1'b1;
        bit_in = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(elem_pos == 0 && elem_neg == 0, "R1", "true outputs in reset", {elem_pos, elem_neg}, 0);
            check(elem_pos_n == 1 && elem_neg_n == 1, "R1", "complements in reset", {elem_pos_n, elem_neg_n}, 3);
        end
        rst = 1'b0;
    endtask

    // Drive n slots from bits/vals and compare every output cycle (R2 R3 R8 R9).
    task automatic run(input int n, input string tag);
        logic h, a;
        int pos_cnt, neg_cnt, exp_pos_cnt, exp_neg_cnt;
        h = 1'b0; a = 1'b0;
        exp_pos_cnt = 0; exp_neg_cnt = 0;
        pos_cnt = 0; neg_cnt = 0;
        for (int s = 0; s < n; s++) begin
            if (vals[s]) begin h = bits[s]; a = 1'b1; end
            held[s] = h; arm[s] = a;
            if (a && h)  exp_pos_cnt += M;
            if (a && !h) exp_neg_cnt += M;
        end
        for (int e = 0; e <= SLOT * n + 1; e++) begin
            int s_cur;
            logic xp, xn;
            s_cur = e / SLOT;
            if (e % SLOT == 0) begin
                bit_valid = (s_cur < n) ? vals[s_cur] : 1'b0;
                bit_in    = (s_cur < n) ? bits[s_cur] : 1'b0;
            end else begin
                // R8: opposite data with valid high off the slot start must be ignored
                bit_valid = 1'b1;
                bit_in    = (s_cur < n) ? ~bits[s_cur] : 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            xp = 1'b0; xn = 1'b0;
            if (e >= P + 1 && ((e - (P + 1)) % 2 == 0)) begin
                int s_p;
                s_p = (e - (P + 1)) / SLOT;
                if (s_p < n && arm[s_p]) begin
                    xp = held[s_p];
                    xn = ~held[s_p];
                end
            end
            check(elem_pos == xp, "R2", {tag, " positive phase per cycle"}, elem_pos, xp);
            check(elem_neg == xn, "R3", {tag, " negative phase per cycle"}, elem_neg, xn);
            check(elem_pos_n == ~elem_pos && elem_neg_n == ~elem_neg, "R7", {tag, " complement mirror"},
                  {elem_pos_n, elem_neg_n}, {~elem_pos, ~elem_neg});
            check(!(elem_pos && elem_neg), "R4", {tag, " phases exclusive"}, {elem_pos, elem_neg}, 0);
            if (elem_pos) pos_cnt++;
            if (elem_neg) neg_cnt++;
        end
        check(pos_cnt == exp_pos_cnt, "R6", {tag, " positive pulse count"}, pos_cnt, exp_pos_cnt);
        check(neg_cnt == exp_neg_cnt, "R6", {tag, " negative pulse count"}, neg_cnt, exp_neg_cnt);
    endtask

    // R5: a pulse is followed by an idle cycle
    logic prev_any = 1'b0;
    always @(negedge clk) begin
        if (!rst && checks > 0) begin
            if (prev_any) check(!(elem_pos || elem_neg), "R5", "idle after pulse", {elem_pos, elem_neg}, 0);
        end
        prev_any = !rst && (elem_pos || elem_neg);
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(3);

        // Random stream, every slot valid
        for (int s = 0; s < 96; s++) begin bits[s] = next_rand(); vals[s] = 1'b1; end
        run(96, "random");

        // Mid-stream reset, then first slot invalid (R8: no pulse before capture) and sparse valid
        do_reset(2);
        for (int s = 0; s < 96; s++) begin
            bits[s] = next_rand();
            vals[s] = (s == 0) ? 1'b0 : (next_rand() | next_rand());
        end
        vals[1] = 1'b0;
        run(96, "sparse");

        // Uniform ones
        do_reset(1);
        for (int s = 0; s < 16; s++) begin bits[s] = 1'b1; vals[s] = 1'b1; end
        run(16, "ones");

        // Uniform zeros
        do_reset(1);
        for (int s = 0; s < 16; s++) begin bits[s] = 1'b0; vals[s] = 1'b1; end
        run(16, "zeros");

        // Alternating with a long gap that repeats the last bit (R8)
        do_reset(1);
        for (int s = 0; s < 24; s++) begin bits[s] = s[0]; vals[s] = (s < 5 || s > 12); end
        run(24, "gap");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule